// File: doc/BRIEF.md
# Full-Bridge Commutation Controller with Adaptive Dead Time

This block is the digital control core of a full-bridge gate driver. It decides which diagonal pair of MOSFETs conducts. Pair A is high-left with low-right. Pair B is high-right with low-left. It drives four gate-enable outputs. Every change from one pair to the other is break-before-make, with a non-overlap gap between them. The gap ends when the half bridge that is switching reports that its falling slope has finished. The gap is never shorter than a fixed minimum, and a timeout ends it if that report never arrives.

Commutation comes from one of two sources, picked by a static strap: an internal oscillator pulse or an external drive input. A second strap sets how the selected source is used. With the divider on, each falling edge of the source swaps the pair, which halves the frequency and gives an exact 50% duty. With the divider off, the level of the source selects the pair directly.

Power sequencing is handled here too. The bridge runs only while the supply is good and start-up release is asserted. Any loss of either returns the block to its idle state. A bridge-off input forces all gates low and overrides everything else. Each time the block leaves idle, it drives pair A after one minimum gap.

Top module: `fullbridge_commutator`

## Requirements
- R1: While reset is asserted, and right after it is released, all four gate enables are 0.
- R2: No gate is enabled until both supplyOk and startRelease have been high after synchronization. Once they have, the first pair driven is pair A (gateEn = 4'b0011), after a gap of exactly MIN_DEAD cycles with all gates low.
- R3: If supplyOk or startRelease goes low, all gates go low and the block returns to idle. On recovery it repeats the R2 start sequence.
- R4: bridgeOff high forces gateEn to 0 in the cycle its synchronized value is high. This overrides every other condition, and the start sequence is repeated afterwards.
- R5: With divEn = 1, each falling edge of the selected source toggles the target pair. The bridge therefore swaps pairs once per source period, and no pair change follows a rising edge.
- R6: With divEn = 0, the pair follows the source level: a high source selects pair A and a low source selects pair B.
- R7: useExt = 1 selects extDrive as the source and ignores oscPulse. useExt = 0 selects oscPulse and ignores extDrive.
- R8: gateEn only ever takes the values 0, 4'b0011 (pair A) or 4'b1100 (pair B). A change between the two pairs always passes through at least one all-low cycle.
- R9: A gap ends at the first cycle in which its count has reached MIN_DEAD−1 and the slope-done input of the switching side has been seen during the gap. The switching side is slopeDoneLeft when moving to pair B and slopeDoneRight when moving to pair A. The gap therefore lasts at least MIN_DEAD all-low cycles.
- R10: If the slope-done input of the switching side stays low, the gap ends after exactly TIMEOUT all-low cycles.
- R11: All asynchronous inputs pass through two flip-flop stages. A change applied before clock edge k first affects the outputs after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscPulse | input | 1 | Internal oscillator square wave (asynchronous) |
| extDrive | input | 1 | External commutation input (asynchronous) |
| useExt | input | 1 | Static strap: 1 selects extDrive, 0 selects oscPulse |
| divEn | input | 1 | Static strap: 1 toggles on falling edges, 0 follows the source level |
| slopeDoneLeft | input | 1 | Left half-bridge falling slope finished (asynchronous) |
| slopeDoneRight | input | 1 | Right half-bridge falling slope finished (asynchronous) |
| supplyOk | input | 1 | Supply above the reset level (asynchronous) |
| startRelease | input | 1 | Start-up release (asynchronous) |
| bridgeOff | input | 1 | Force all gates off (asynchronous) |
| gateEn | output | 4 | Gate enables: [0] high-left, [1] low-right, [2] high-right, [3] low-left |

## Verification
The hardest cases to reach are the gaps that are not ended by a timely slope report. One is the timeout path. The other is the asymmetric case where only one side ever reports its slope, so one direction of commutation is fast and the other times out. The stimulus holds both slope inputs low for a slow oscillator, then holds only the left input high. The longest and shortest all-low runs are then measured against TIMEOUT and MIN_DEAD, while a behavioural model checks every cycle, including bridge-off and supply-loss events injected while a pair is conducting.

// File: rtl/fullbridge_commutator_pkg.sv
package fullbridge_commutator_pkg;

  // strobes issued by the control FSM to the datapath
  typedef struct packed {
    logic cntClr;   // restart the gap counter and slope memory
    logic cntInc;   // advance the gap counter
    logic destB;    // pair the bridge is heading to (1 = pair B)
  } ctrlStrobe_t;

  // conditions reported by the datapath to the control FSM
  typedef struct packed {
    logic run;      // supply good, released, not disabled
    logic offSync;  // synchronized bridge-off
    logic target;   // wanted pair (1 = pair B)
    logic slopeOk;  // switching side reported its slope in this gap
    logic atMin;    // gap counter reached the minimum
    logic atTmo;    // gap counter reached the timeout
  } dpStatus_t;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_GAP,
    PH_DRIVE
  } phase_t;

  localparam logic [3:0] GATES_A = 4'b0011;
  localparam logic [3:0] GATES_B = 4'b1100;

endpackage

// File: rtl/fullbridge_sync.sv
module fullbridge_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= '0;
      syncOut <= '0;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end

endmodule

// File: rtl/fullbridge_datapath.sv
module fullbridge_datapath
  import fullbridge_commutator_pkg::*;
#(
  parameter int MIN_DEAD = 16,
  parameter int TIMEOUT  = 256
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        oscPulse,
  input  logic        extDrive,
  input  logic        useExt,
  input  logic        divEn,
  input  logic        slopeDoneLeft,
  input  logic        slopeDoneRight,
  input  logic        supplyOk,
  input  logic        startRelease,
  input  logic        bridgeOff,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);

  localparam int NSYNC = 7;
  localparam int CNT_W = $clog2(TIMEOUT + 1);
  localparam logic [CNT_W-1:0] MIN_LAST = CNT_W'(MIN_DEAD - 1);
  localparam logic [CNT_W-1:0] TMO_LAST = CNT_W'(TIMEOUT - 1);

  logic [NSYNC-1:0] rawIn;
  logic [NSYNC-1:0] syncIn;
  logic oscS, extS, slopeLS, slopeRS, supplyS, releaseS, offS;

  assign rawIn = {bridgeOff, startRelease, supplyOk, slopeDoneRight,
                  slopeDoneLeft, extDrive, oscPulse};

  fullbridge_sync #(.WIDTH(NSYNC)) uSync (
    .clk    (clk),
    .rstN   (rstN),
    .asyncIn(rawIn),
    .syncOut(syncIn)
  );

  assign {offS, releaseS, supplyS, slopeRS, slopeLS, extS, oscS} = syncIn;

  logic srcNow, srcPrev, srcFall, runNow;
  logic targetQ, slopeSeen, slopeNow;
  logic [CNT_W-1:0] gapCnt;

  assign srcNow   = useExt ? extS : oscS;
  assign srcFall  = srcPrev & ~srcNow;
  assign runNow   = supplyS & releaseS & ~offS;
  assign slopeNow = strobe.destB ? slopeLS : slopeRS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcPrev <= 1'b0;
      targetQ <= 1'b0;
    end else begin
      srcPrev <= srcNow;
      if (!runNow)     targetQ <= 1'b0;
      else if (divEn)  targetQ <= srcFall ? ~targetQ : targetQ;
      else             targetQ <= ~srcNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt    <= '0;
      slopeSeen <= 1'b0;
    end else if (strobe.cntClr) begin
      gapCnt    <= '0;
      slopeSeen <= 1'b0;
    end else begin
      if (strobe.cntInc) gapCnt <= gapCnt + 1'b1;
      if (slopeNow)      slopeSeen <= 1'b1;
    end
  end

  always_comb begin
    status.run     = runNow;
    status.offSync = offS;
    status.target  = targetQ;
    status.slopeOk = slopeSeen | slopeNow;
    status.atMin   = gapCnt >= MIN_LAST;
    status.atTmo   = gapCnt >= TMO_LAST;
  end

endmodule

// File: rtl/fullbridge_control.sv
module fullbridge_control
  import fullbridge_commutator_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic [3:0]  gateRaw
);

  phase_t phase, phaseNxt;
  logic   activeB, initGap;
  logic   swapReq, gapDone;

  assign swapReq = (phase == PH_DRIVE) && (status.target != activeB);
  assign gapDone = (status.atMin && (initGap || status.slopeOk)) || status.atTmo;

  always_comb begin
    phaseNxt      = phase;
    strobe.cntClr = 1'b0;
    strobe.cntInc = 1'b0;
    strobe.destB  = activeB;
    if (!status.run) begin
      phaseNxt      = PH_IDLE;
      strobe.cntClr = 1'b1;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          phaseNxt      = PH_GAP;
          strobe.cntClr = 1'b1;
        end
        PH_GAP: begin
          if (gapDone) phaseNxt = PH_DRIVE;
          else         strobe.cntInc = 1'b1;
        end
        PH_DRIVE: begin
          if (swapReq) begin
            phaseNxt      = PH_GAP;
            strobe.cntClr = 1'b1;
          end
        end
        default: phaseNxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      activeB <= 1'b0;
      initGap <= 1'b0;
    end else begin
      phase <= phaseNxt;
      if (!status.run || phase == PH_IDLE) begin
        activeB <= 1'b0;
        initGap <= status.run;
      end else if (swapReq) begin
        activeB <= status.target;
        initGap <= 1'b0;
      end
    end
  end

  assign gateRaw = (phase != PH_DRIVE) ? 4'b0000 : (activeB ? GATES_B : GATES_A);

endmodule

// File: rtl/fullbridge_commutator.sv
module fullbridge_commutator
  import fullbridge_commutator_pkg::*;
#(
  parameter int MIN_DEAD = 16,
  parameter int TIMEOUT  = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       oscPulse,
  input  logic       extDrive,
  input  logic       useExt,
  input  logic       divEn,
  input  logic       slopeDoneLeft,
  input  logic       slopeDoneRight,
  input  logic       supplyOk,
  input  logic       startRelease,
  input  logic       bridgeOff,
  output logic [3:0] gateEn
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;
  logic [3:0]  gateRaw;

  fullbridge_datapath #(.MIN_DEAD(MIN_DEAD), .TIMEOUT(TIMEOUT)) uDp (
    .clk           (clk),
    .rstN          (rstN),
    .oscPulse      (oscPulse),
    .extDrive      (extDrive),
    .useExt        (useExt),
    .divEn         (divEn),
    .slopeDoneLeft (slopeDoneLeft),
    .slopeDoneRight(slopeDoneRight),
    .supplyOk      (supplyOk),
    .startRelease  (startRelease),
    .bridgeOff     (bridgeOff),
    .strobe        (strobe),
    .status        (status)
  );

  fullbridge_control uCtl (
    .clk    (clk),
    .rstN   (rstN),
    .status (status),
    .strobe (strobe),
    .gateRaw(gateRaw)
  );

  // the synchronized disable masks the gates in the same cycle
  assign gateEn = gateRaw & {4{~status.offSync}};

endmodule

// File: rtl/fullbridge_commutator_sva.sv
module fullbridge_commutator_sva #(
  parameter int MIN_DEAD = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       bridgeOff,
  input logic       supplyOk,
  input logic [3:0] gateEn
);

  int lowRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lowRun <= 0;
    else if (gateEn != 0) lowRun <= 0;
    else if (lowRun < MIN_DEAD) lowRun <= lowRun + 1;
  end

  assert_legal_pairs_R8: assert property (@(posedge clk) disable iff (!rstN)
    (gateEn == 4'b0000) || (gateEn == 4'b0011) || (gateEn == 4'b1100));

  assert_break_before_make_R8: assert property (@(posedge clk) disable iff (!rstN)
    (gateEn != 4'b0000) |=> (gateEn == 4'b0000) || $stable(gateEn));

  assert_min_gap_R9: assert property (@(posedge clk) disable iff (!rstN)
    (gateEn != 4'b0000 && lowRun != 0) |-> lowRun >= MIN_DEAD);

  assert_off_override_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(bridgeOff, 2) |-> gateEn == 4'b0000);

  assert_supply_loss_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(supplyOk, 3) |-> gateEn == 4'b0000);

endmodule

bind fullbridge_commutator fullbridge_commutator_sva #(.MIN_DEAD(MIN_DEAD)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .bridgeOff(bridgeOff),
  .supplyOk (supplyOk),
  .gateEn   (gateEn)
);

// File: tb/fullbridge_commutator_test.sv
`timescale 1ns/1ps
module fullbridge_commutator_test;

  localparam int MIN = 16;
  localparam int TMO = 256;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic oscPulse = 0, extDrive = 0, useExt = 0, divEn = 1;
  logic slopeDoneLeft = 0, slopeDoneRight = 0;
  logic supplyOk = 0, startRelease = 0, bridgeOff = 0;
  logic [3:0] gateEn;

  always #2.5 clk = ~clk;

  fullbridge_commutator #(.MIN_DEAD(MIN), .TIMEOUT(TMO)) uut (
    .clk(clk), .rstN(rstN), .oscPulse(oscPulse), .extDrive(extDrive),
    .useExt(useExt), .divEn(divEn), .slopeDoneLeft(slopeDoneLeft),
    .slopeDoneRight(slopeDoneRight), .supplyOk(supplyOk),
    .startRelease(startRelease), .bridgeOff(bridgeOff), .gateEn(gateEn)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string curReq = "R1";

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: gateEn=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkInt(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: value=%0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: delay lines for synchronization, then phases
  bit q1[7], q2[7];
  int mPhase = 0;       // 0 idle, 1 gap, 2 driving
  int mCnt = 0;
  bit mToB = 0, mWant = 0, mFirst = 0, mSeen = 0, mPrevSrc = 0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foreach (q1[i]) begin q1[i] = 0; q2[i] = 0; end
      mPhase = 0; mCnt = 0; mToB = 0; mWant = 0; mFirst = 0; mSeen = 0; mPrevSrc = 0;
    end else begin
      bit src, run, hit, nWant;
      src = useExt ? q2[1] : q2[0];
      run = q2[5] && q2[6] && !q2[4];
      nWant = mWant;
      if (!run) nWant = 0;
      else if (divEn) begin if (mPrevSrc && !src) nWant = !mWant; end
      else nWant = !src;
      if (!run) begin
        mPhase = 0; mCnt = 0;
      end else if (mPhase == 0) begin
        mPhase = 1; mCnt = 0; mFirst = 1; mSeen = 0; mToB = 0;
      end else if (mPhase == 1) begin
        hit = mToB ? q2[2] : q2[3];
        if ((mCnt >= MIN - 1 && (mFirst || mSeen || hit)) || mCnt >= TMO - 1) mPhase = 2;
        else begin mCnt++; mSeen = mSeen | hit; end
      end else if (mWant != mToB) begin
        mPhase = 1; mToB = mWant; mCnt = 0; mFirst = 0; mSeen = 0;
      end
      if (!run) begin mToB = 0; mFirst = 0; end
      mWant = nWant;
      mPrevSrc = src;
      foreach (q1[i]) q2[i] = q1[i];
      q1[0] = oscPulse; q1[1] = extDrive; q1[2] = slopeDoneLeft;
      q1[3] = slopeDoneRight; q1[4] = bridgeOff; q1[5] = supplyOk; q1[6] = startRelease;
    end
  end

  function automatic logic [3:0] modelGates();
    if (mPhase != 2 || q2[4]) return 4'b0000;
    return mToB ? 4'b1100 : 4'b0011;
  endfunction

  // per-cycle comparison plus run-length statistics
  int lowLen = 0, maxLow = 0, minLow = 1 << 30, bEntries = 0;
  logic [3:0] prevGate = 0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(curReq, gateEn, modelGates());
      if (gateEn == 0) lowLen++;
      else begin
        if (prevGate == 0 && lowLen > 0) begin
          if (lowLen > maxLow) maxLow = lowLen;
          if (lowLen < minLow) minLow = lowLen;
        end
        lowLen = 0;
      end
      if (gateEn == 4'b1100 && prevGate != 4'b1100) bEntries++;
      prevGate = gateEn;
    end
  end

  task automatic clearStats();
    maxLow = 0; minLow = 1 << 30; bEntries = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runWave(int half, int periods, bit ext);
    for (int c = 0; c < 2 * half * periods; c++) begin
      @(negedge clk);
      if (ext) begin
        extDrive = ((c / half) % 2) == 0;
        oscPulse = ((c / 7) % 2) == 0;
      end else oscPulse = ((c / half) % 2) == 0;
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    check("R1", gateEn, 4'b0000);
    rstN = 1;
    @(negedge clk);
    check("R1", gateEn, 4'b0000);

    // R2: supply alone is not enough
    curReq = "R2";
    supplyOk = 1; slopeDoneLeft = 1; slopeDoneRight = 1;
    idle(40);
    check("R2", gateEn, 4'b0000);
    startRelease = 1;
    idle(MIN + 1);
    check("R2", gateEn, 4'b0000);
    idle(3);
    check("R2", gateEn, 4'b0011);

    // R5 R7: divider on internal oscillator, slopes ready
    curReq = "R5"; clearStats();
    runWave(40, 6, 0);
    idle(40);
    checkInt("R5", bEntries, 3);
    checkInt("R9", minLow, MIN);
    checkInt("R9", maxLow, MIN);

    // R7: divider on external input, oscillator toggling and ignored
    curReq = "R7"; useExt = 1; clearStats();
    runWave(40, 6, 1);
    idle(40);
    checkInt("R7", bEntries, 3);

    // R6: level pass-through
    curReq = "R6"; divEn = 0;
    runWave(60, 4, 1);
    extDrive = 1; idle(40);
    check("R6", gateEn, 4'b0011);
    extDrive = 0; idle(40);
    check("R6", gateEn, 4'b1100);
    extDrive = 1; idle(40);
    check("R6", gateEn, 4'b0011);

    // R10: no slope reports at all
    curReq = "R10"; divEn = 1; useExt = 0;
    slopeDoneLeft = 0; slopeDoneRight = 0; clearStats();
    runWave(400, 2, 0);
    idle(300);
    checkInt("R10", maxLow, TMO);

    // R9: only the left side reports
    curReq = "R9"; slopeDoneLeft = 1; clearStats();
    runWave(400, 4, 0);
    idle(300);
    checkInt("R9", minLow, MIN);
    checkInt("R9", maxLow, TMO);

    // R11 R4: bridge-off while driving
    slopeDoneRight = 1;
    curReq = "R4";
    idle(5);
    check("R4", gateEn, 4'b0011);
    bridgeOff = 1;
    @(negedge clk);
    check("R11", gateEn, 4'b0011);
    @(negedge clk);
    check("R4", gateEn, 4'b0000);
    oscPulse = 1; idle(3); oscPulse = 0; idle(10);
    check("R4", gateEn, 4'b0000);
    bridgeOff = 0;
    idle(MIN + 6);
    check("R4", gateEn, 4'b0011);

    // R3: supply loss and recovery
    curReq = "R3";
    runWave(40, 1, 0);
    idle(10);
    check("R3", gateEn, 4'b1100);
    supplyOk = 0;
    idle(3);
    check("R3", gateEn, 4'b0000);
    idle(20);
    check("R3", gateEn, 4'b0000);
    supplyOk = 1;
    idle(MIN + 6);
    check("R3", gateEn, 4'b0011);
    startRelease = 0;
    idle(4);
    check("R3", gateEn, 4'b0000);
    startRelease = 1;
    idle(MIN + 6);
    check("R3", gateEn, 4'b0011);

    idle(5);
    finishRun();
  end

endmodule